// File: doc/BRIEF.md
# In-Order Function Unit Result Queue

This block sits at the output of one function unit in a scoreboard-controlled core. The unit pushes each finished result into it, tagged with a destination register number and a sequence tag. The result is held there until the scoreboard grants a write for that tag. Because results wait here, the core can launch an instruction without first resolving any pending write hazard.

Results leave only from the head, one per granted cycle, and go out on a register file write port. Results therefore reach the register file in the order the unit produced them, which is program order. While an entry waits, it is also a forwarding source. A set of lookup ports compares a requested register number against every held entry. On a match, the port returns the youngest matching value. With no match, it passes through the register file value given with the lookup.

Top module: `fu_result_queue`

## Requirements
- R1: After reset the queue holds nothing: empty_o=1, push_ready_o=1, rf_we_o=0, grant_err_o=0 with grant idle, and every look_hit_o bit is 0.
- R2: A push is taken when push_valid_i and push_ready_o are both high. The queue holds at most DEPTH (4) entries. push_ready_o is low while 4 entries are held and no write is taken in that cycle.
- R3: With 4 entries held, a push and a taken write in the same cycle are both accepted, and the entry count stays at 4.
- R4: A write is taken, with rf_we_o high in the same cycle, only when grant_valid_i is high, the queue is not empty and grant_seq_i equals the head entry's sequence tag. rf_waddr_o and rf_wdata_o then carry the head entry's register number and data.
- R5: Entries are written to the register file in exactly the order in which they were pushed.
- R6: A grant that arrives on an empty queue, or whose tag differs from the head's tag, causes no write. grant_err_o is high in that cycle and the queue contents are unchanged.
- R7: A lookup whose register number matches one or more held entries gives look_hit_o=1 and the data of the most recently pushed matching entry.
- R8: A lookup with no matching held entry gives look_hit_o=0, and look_data_o equals that port's look_rf_data_i slice.
- R9: A pushed entry is visible to lookups from the cycle after its push. An entry being written out in a cycle is still visible to lookups in that cycle.
- R10: empty_o is high exactly when no entries are held. No write is taken while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Function unit offers a result |
| push_ready_o | output | 1 | Queue can take the offered result |
| push_reg_i | input | REG_W | Destination register of the offered result |
| push_seq_i | input | SEQ_W | Sequence tag of the offered result |
| push_data_i | input | DATA_W | Result value |
| grant_valid_i | input | 1 | Scoreboard write grant |
| grant_seq_i | input | SEQ_W | Tag the grant is issued for |
| grant_err_o | output | 1 | Grant did not match the head entry (or the queue was empty) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | REG_W | Register file write address |
| rf_wdata_o | output | DATA_W | Register file write data |
| look_reg_i | input | N_LOOK*REG_W | Register number per lookup port |
| look_rf_data_i | input | N_LOOK*DATA_W | Register file value per lookup port |
| look_hit_o | output | N_LOOK | Queue match per lookup port |
| look_data_o | output | N_LOOK*DATA_W | Operand value per lookup port |
| empty_o | output | 1 | No entries held |

## Verification
A corrupted read pointer or count does not stay hidden. In the cycle of the next grant it puts the wrong register or data on the write port, or it raises grant_err_o for a tag that should match. An age-ordering fault in the forwarding path appears as soon as two held entries share a destination, because the returned value is then the older one. An off-by-one in the fullness logic shows on push_ready_o in the first cycle the queue reaches four entries, and a lost or duplicated entry shows on the write port when the queue drains.

// File: rtl/frq_pkg.sv
package frq_pkg;
  typedef enum logic [1:0] {
    GNT_IDLE   = 2'd0,
    GNT_TAKE   = 2'd1,
    GNT_REJECT = 2'd2
  } gnt_e;

  function automatic gnt_e classify_grant(logic gnt_vld, logic head_vld, logic tag_eq);
    if (!gnt_vld) return GNT_IDLE;
    if (head_vld && tag_eq) return GNT_TAKE;
    return GNT_REJECT;
  endfunction
endpackage

// File: rtl/frq_store.sv
module frq_store #(
  parameter int DEPTH  = 4,
  parameter int REG_W  = 7,
  parameter int SEQ_W  = 4,
  parameter int DATA_W = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [REG_W-1:0]               push_reg_i,
  input  logic [SEQ_W-1:0]               push_seq_i,
  input  logic [DATA_W-1:0]              push_data_i,
  input  logic                           pop_i,
  output logic [CNT_W-1:0]               count_o,
  output logic [DEPTH-1:0]               ord_valid_o,
  output logic [DEPTH-1:0][REG_W-1:0]    ord_reg_o,
  output logic [DEPTH-1:0][SEQ_W-1:0]    ord_seq_o,
  output logic [DEPTH-1:0][DATA_W-1:0]   ord_data_o
);
  logic [DEPTH-1:0][REG_W-1:0]  mem_reg;
  logic [DEPTH-1:0][SEQ_W-1:0]  mem_seq;
  logic [DEPTH-1:0][DATA_W-1:0] mem_data;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop_i)  rd_ptr <= rd_ptr + PTR_W'(1);
      cnt <= cnt + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      mem_reg[wr_ptr]  <= push_reg_i;
      mem_seq[wr_ptr]  <= push_seq_i;
      mem_data[wr_ptr] <= push_data_i;
    end
  end

  // age-ordered view: index 0 is the head (oldest)
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      ord_valid_o[k] = CNT_W'(k) < cnt;
      ord_reg_o[k]   = mem_reg[rd_ptr + PTR_W'(k)];
      ord_seq_o[k]   = mem_seq[rd_ptr + PTR_W'(k)];
      ord_data_o[k]  = mem_data[rd_ptr + PTR_W'(k)];
    end
  end

  assign count_o = cnt;
endmodule

// File: rtl/frq_grant.sv
module frq_grant #(
  parameter int SEQ_W = 4
) (
  input  logic             grant_valid_i,
  input  logic [SEQ_W-1:0] grant_seq_i,
  input  logic             head_valid_i,
  input  logic [SEQ_W-1:0] head_seq_i,
  output logic             take_o,
  output logic             err_o
);
  import frq_pkg::*;
  gnt_e kind;

  always_comb begin
    kind   = classify_grant(grant_valid_i, head_valid_i, grant_seq_i == head_seq_i);
    take_o = kind == GNT_TAKE;
    err_o  = kind == GNT_REJECT;
  end
endmodule

// File: rtl/frq_fwd.sv
module frq_fwd #(
  parameter int DEPTH  = 4,
  parameter int REG_W  = 7,
  parameter int DATA_W = 64
) (
  input  logic [DEPTH-1:0]              ord_valid_i,
  input  logic [DEPTH-1:0][REG_W-1:0]   ord_reg_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]  ord_data_i,
  input  logic [REG_W-1:0]              look_reg_i,
  input  logic [DATA_W-1:0]             rf_data_i,
  output logic                          hit_o,
  output logic [DATA_W-1:0]             data_o
);
  // scan oldest to youngest; the last match wins
  always_comb begin
    hit_o  = 1'b0;
    data_o = rf_data_i;
    for (int k = 0; k < DEPTH; k++) begin
      if (ord_valid_i[k] && ord_reg_i[k] == look_reg_i) begin
        hit_o  = 1'b1;
        data_o = ord_data_i[k];
      end
    end
  end
endmodule

// File: rtl/fu_result_queue.sv
module fu_result_queue #(
  parameter int DEPTH  = 4,
  parameter int REG_W  = 7,
  parameter int SEQ_W  = 4,
  parameter int DATA_W = 64,
  parameter int N_LOOK = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_valid_i,
  output logic                     push_ready_o,
  input  logic [REG_W-1:0]         push_reg_i,
  input  logic [SEQ_W-1:0]         push_seq_i,
  input  logic [DATA_W-1:0]        push_data_i,
  input  logic                     grant_valid_i,
  input  logic [SEQ_W-1:0]         grant_seq_i,
  output logic                     grant_err_o,
  output logic                     rf_we_o,
  output logic [REG_W-1:0]         rf_waddr_o,
  output logic [DATA_W-1:0]        rf_wdata_o,
  input  logic [N_LOOK*REG_W-1:0]  look_reg_i,
  input  logic [N_LOOK*DATA_W-1:0] look_rf_data_i,
  output logic [N_LOOK-1:0]        look_hit_o,
  output logic [N_LOOK*DATA_W-1:0] look_data_o,
  output logic                     empty_o
);
  logic [CNT_W-1:0]             cnt;
  logic [DEPTH-1:0]             ord_valid;
  logic [DEPTH-1:0][REG_W-1:0]  ord_reg;
  logic [DEPTH-1:0][SEQ_W-1:0]  ord_seq;
  logic [DEPTH-1:0][DATA_W-1:0] ord_data;
  logic take, push_en, full;

  assign full         = cnt == CNT_W'(DEPTH);
  assign push_ready_o = !full || take;
  assign push_en      = push_valid_i && push_ready_o;
  assign empty_o      = !ord_valid[0];

  frq_store #(
    .DEPTH(DEPTH), .REG_W(REG_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_en),
    .push_reg_i (push_reg_i),
    .push_seq_i (push_seq_i),
    .push_data_i(push_data_i),
    .pop_i      (take),
    .count_o    (cnt),
    .ord_valid_o(ord_valid),
    .ord_reg_o  (ord_reg),
    .ord_seq_o  (ord_seq),
    .ord_data_o (ord_data)
  );

  frq_grant #(.SEQ_W(SEQ_W)) u_grant (
    .grant_valid_i(grant_valid_i),
    .grant_seq_i  (grant_seq_i),
    .head_valid_i (ord_valid[0]),
    .head_seq_i   (ord_seq[0]),
    .take_o       (take),
    .err_o        (grant_err_o)
  );

  assign rf_we_o    = take;
  assign rf_waddr_o = ord_reg[0];
  assign rf_wdata_o = ord_data[0];

  for (genvar p = 0; p < N_LOOK; p++) begin : g_look
    frq_fwd #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_fwd (
      .ord_valid_i(ord_valid),
      .ord_reg_i  (ord_reg),
      .ord_data_i (ord_data),
      .look_reg_i (look_reg_i[p*REG_W +: REG_W]),
      .rf_data_i  (look_rf_data_i[p*DATA_W +: DATA_W]),
      .hit_o      (look_hit_o[p]),
      .data_o     (look_data_o[p*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/frq_checks.sv
module frq_checks #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 64,
  parameter int N_LOOK = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     push_valid_i,
  input logic                     push_ready_o,
  input logic                     grant_valid_i,
  input logic                     grant_err_o,
  input logic                     rf_we_o,
  input logic                     empty_o,
  input logic [CNT_W-1:0]         cnt,
  input logic [N_LOOK*DATA_W-1:0] look_rf_data_i,
  input logic [N_LOOK-1:0]        look_hit_o,
  input logic [N_LOOK*DATA_W-1:0] look_data_o
);
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));

  p_full_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(DEPTH) && !rf_we_o) |-> !push_ready_o);

  p_full_swap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(DEPTH) && rf_we_o && push_valid_i) |=> cnt == CNT_W'(DEPTH));

  p_write_needs_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> grant_valid_i && !grant_err_o);

  p_reject_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_err_o && !push_valid_i) |=> cnt == $past(cnt));

  p_empty_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !rf_we_o);

  p_empty_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o == (cnt == '0));

  for (genvar p = 0; p < N_LOOK; p++) begin : g_pass
    p_miss_passthru_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !look_hit_o[p] |-> look_data_o[p*DATA_W +: DATA_W] == look_rf_data_i[p*DATA_W +: DATA_W]);
  end
endmodule

bind fu_result_queue frq_checks #(.DEPTH(DEPTH), .DATA_W(DATA_W), .N_LOOK(N_LOOK)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .push_valid_i  (push_valid_i),
  .push_ready_o  (push_ready_o),
  .grant_valid_i (grant_valid_i),
  .grant_err_o   (grant_err_o),
  .rf_we_o       (rf_we_o),
  .empty_o       (empty_o),
  .cnt           (cnt),
  .look_rf_data_i(look_rf_data_i),
  .look_hit_o    (look_hit_o),
  .look_data_o   (look_data_o)
);

// File: tb/fu_result_queue_tb.sv
`timescale 1ns/1ps
module fu_result_queue_tb;
  localparam int DEPTH = 4, REG_W = 7, SEQ_W = 4, DATA_W = 64, N_LOOK = 2;

  typedef struct packed {
    logic [REG_W-1:0]  rg;
    logic [SEQ_W-1:0]  sq;
    logic [DATA_W-1:0] dt;
  } ent_t;

  logic clk_i = 0, rst_ni = 0;
  logic push_valid_i = 0, grant_valid_i = 0;
  logic [REG_W-1:0]  push_reg_i = '0;
  logic [SEQ_W-1:0]  push_seq_i = '0, grant_seq_i = '0;
  logic [DATA_W-1:0] push_data_i = '0;
  logic [N_LOOK*REG_W-1:0]  look_reg_i = '0;
  logic [N_LOOK*DATA_W-1:0] look_rf_data_i = '0;
  logic push_ready_o, grant_err_o, rf_we_o, empty_o;
  logic [REG_W-1:0]  rf_waddr_o;
  logic [DATA_W-1:0] rf_wdata_o;
  logic [N_LOOK-1:0] look_hit_o;
  logic [N_LOOK*DATA_W-1:0] look_data_o;

  int n_tests = 0, n_fail = 0;
  logic [SEQ_W-1:0] seq_ctr = '0;
  ent_t model[$];
  ent_t exp_wr[$];

  always #2.5 clk_i = ~clk_i;

  fu_result_queue #(.DEPTH(DEPTH), .REG_W(REG_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W), .N_LOOK(N_LOOK)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_valid_i(push_valid_i), .push_ready_o(push_ready_o),
    .push_reg_i(push_reg_i), .push_seq_i(push_seq_i), .push_data_i(push_data_i),
    .grant_valid_i(grant_valid_i), .grant_seq_i(grant_seq_i), .grant_err_o(grant_err_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .look_reg_i(look_reg_i), .look_rf_data_i(look_rf_data_i),
    .look_hit_o(look_hit_o), .look_data_o(look_data_o), .empty_o(empty_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: register file writes must match pushes in order (R5)
  always @(negedge clk_i) begin
    if (rst_ni && rf_we_o) begin
      if (exp_wr.size() == 0) begin
        chk(0, "R5 unexpected write", {57'd0, rf_waddr_o}, '0);
      end else begin
        chk(rf_waddr_o == exp_wr[0].rg, "R5 addr", {57'd0, rf_waddr_o}, {57'd0, exp_wr[0].rg});
        chk(rf_wdata_o == exp_wr[0].dt, "R5 data", rf_wdata_o, exp_wr[0].dt);
        void'(exp_wr.pop_front());
      end
    end
  end

  // lk < 0: random lookup registers; otherwise both ports look up lk
  task automatic step(input bit pv, input logic [REG_W-1:0] pr, input logic [DATA_W-1:0] pd,
                      input bit gv, input bit gbad, input int lk);
    bit good, exp_ready;
    @(posedge clk_i); #1;
    push_valid_i  = pv;
    push_reg_i    = pr;
    push_seq_i    = seq_ctr;
    push_data_i   = pd;
    grant_valid_i = gv;
    if (model.size() > 0) grant_seq_i = gbad ? model[0].sq + SEQ_W'(1) : model[0].sq;
    else grant_seq_i = SEQ_W'($urandom);
    for (int p = 0; p < N_LOOK; p++) begin
      look_reg_i[p*REG_W +: REG_W] = (lk < 0) ? REG_W'($urandom_range(0, 7)) : REG_W'(lk);
      look_rf_data_i[p*DATA_W +: DATA_W] = {$urandom, $urandom};
    end
    #0.5;
    good = gv && model.size() > 0 && grant_seq_i == model[0].sq;
    exp_ready = model.size() < DEPTH || good;
    chk(push_ready_o == exp_ready, (model.size() == DEPTH && good) ? "R3 ready on swap" : "R2 ready",
        {63'd0, push_ready_o}, {63'd0, exp_ready});
    chk(rf_we_o == good, "R4 write enable", {63'd0, rf_we_o}, {63'd0, good});
    if (good) begin
      chk(rf_waddr_o == model[0].rg, "R4 head addr", {57'd0, rf_waddr_o}, {57'd0, model[0].rg});
      chk(rf_wdata_o == model[0].dt, "R4 head data", rf_wdata_o, model[0].dt);
    end
    chk(grant_err_o == (gv && !good), "R6 grant error", {63'd0, grant_err_o}, {63'd0, gv && !good});
    chk(empty_o == (model.size() == 0), "R10 empty", {63'd0, empty_o}, {63'd0, model.size() == 0});
    for (int p = 0; p < N_LOOK; p++) begin
      bit h = 0;
      logic [DATA_W-1:0] d = look_rf_data_i[p*DATA_W +: DATA_W];
      foreach (model[k]) if (model[k].rg == look_reg_i[p*REG_W +: REG_W]) begin h = 1; d = model[k].dt; end
      chk(look_hit_o[p] == h, h ? "R7 hit" : "R8 miss", {63'd0, look_hit_o[p]}, {63'd0, h});
      chk(look_data_o[p*DATA_W +: DATA_W] == d, h ? "R7 youngest data" : "R8 rf pass-through",
          look_data_o[p*DATA_W +: DATA_W], d);
    end
    @(negedge clk_i); #0.5;
    if (good) void'(model.pop_front());
    if (pv && exp_ready) begin
      model.push_back('{rg: pr, sq: seq_ctr, dt: pd});
      exp_wr.push_back('{rg: pr, sq: seq_ctr, dt: pd});
      seq_ctr = seq_ctr + SEQ_W'(1);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(empty_o == 1 && push_ready_o == 1 && rf_we_o == 0 && look_hit_o == '0 && grant_err_o == 0,
        "R1 reset state", {59'd0, empty_o, push_ready_o, rf_we_o, look_hit_o}, {59'd0, 5'b11000});
    rst_ni = 1;
    // R9: pushed entry not visible in its push cycle, visible next cycle
    step(1, 7'd1, 64'hA1, 0, 0, 1);
    step(1, 7'd2, 64'hA2, 0, 0, 1);
    step(1, 7'd1, 64'hA3, 0, 0, 1);   // R7: two entries on reg 1
    step(1, 7'd3, 64'hA4, 0, 0, 1);
    step(1, 7'd5, 64'hA5, 0, 0, 5);   // R2: full, push refused
    step(0, 7'd0, 64'h0,  0, 0, 5);   // refused entry absent (R2)
    step(0, 7'd0, 64'h0,  1, 1, 1);   // R6: wrong tag
    step(1, 7'd6, 64'hA6, 1, 0, 1);   // R3: swap while full; R9 drained entry still visible
    step(0, 7'd0, 64'h0,  0, 0, 6);
    repeat (4) step(0, 7'd0, 64'h0, 1, 0, 1);
    step(0, 7'd0, 64'h0,  1, 0, 1);   // R6/R10: grant on empty
    step(0, 7'd0, 64'h0,  0, 0, 2);
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 9) < 6, REG_W'($urandom_range(0, 7)), {$urandom, $urandom},
           $urandom_range(0, 1), $urandom_range(0, 9) == 0, -1);
    while (model.size() > 0) step(0, 7'd0, 64'h0, 1, 0, -1);
    step(0, 7'd0, 64'h0, 0, 0, -1);
    chk(exp_wr.size() == 0, "R5 all written", exp_wr.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule